// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master Sequencer

This block is a single-master sequencer for a two-wire open-drain serial bus (I2C). A host asks it for one of four primitives: a start condition, a stop condition, a byte write that captures the slave's acknowledge, or a byte read that ends with a master acknowledge or not-acknowledge bit. The block never drives either line high. Its two outputs are active-high pull-down enables. A logic one appears on a line when the block releases it and the external pull-up raises it. The data line is read back through `sda_in`.

All bus timing comes from one shared phase length, `PHASE_DLY` clock cycles, which applies to every high, low, setup-of-start, hold and stop interval. A separate shorter count, `SETUP_CYC`, sets how long the data line is settled before the clock is raised after a data change. With a 100 MHz system clock the default of 250 cycles per phase gives a bit rate near 200 kHz. Lowering the count reaches 400 kHz. A command is taken in a single cycle while the block is idle. `busy` covers the whole primitive, and a one-cycle `done` pulse follows the expiry of its last phase.

Top module: `i2c_bitbyte_master`

## Requirements
- R1: While reset is applied, and on the first idle cycles after it, `busy`, `done`, `scl_pull` and `sda_pull` are all 0.
- R2: A start command (`cmd_op`=0) releases SDA, then releases SCL, then pulls SDA low while SCL stays released, then pulls SCL low. It lasts SETUP+3·T cycles and leaves both lines pulled low.
- R3: A stop command (`cmd_op`=1) pulls SDA low, then releases SCL, then releases SDA while SCL stays released. It lasts SETUP+2·T cycles and leaves both lines released.
- R4: A write command (`cmd_op`=2) puts the 8 bits of `cmd_wdata` on SDA, most significant bit first, one bit per SCL high pulse. SDA is released right after each pulse, and a ninth pulse follows.
- R5: `ack_seen` is 1 after a write when SDA was low at the end of the ninth pulse's high phase, and 0 when SDA was high.
- R6: A read command (`cmd_op`=3) releases SDA for 8 SCL pulses and samples it at the end of each high phase. It presents the byte on `rdata`, first sampled bit in bit 7.
- R7: On the ninth pulse of a read, SDA is pulled low when `cmd_rd_ack`=1 (acknowledge) and released when `cmd_rd_ack`=0 (not-acknowledge).
- R8: During a byte write or read, SDA changes only while SCL is pulled low, so no start or stop condition appears inside a byte.
- R9: A command is accepted only when `busy` is 0. A `cmd_valid` raised while busy has no effect and is not remembered.
- R10: `done` is high for exactly one cycle, on the cycle after the last phase expires, with `busy` already 0.
- R11: Each timed phase lasts T = max(`PHASE_DLY`,1) cycles, and each data setup lasts max(`SETUP_CYC`,1) cycles. A write therefore takes 8·(SETUP+2T)+2T cycles and a read takes 16T+SETUP+2T cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| cmd_wdata | input | DATA_W | Byte to transmit for a write |
| cmd_rd_ack | input | 1 | For a read: 1 sends acknowledge, 0 sends not-acknowledge |
| busy | output | 1 | A primitive is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last byte read |
| ack_seen | output | 1 | Acknowledge received on the last write |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA level |

## Verification
The assertions assume that `sda_in` is already synchronous to `clk`. They also assume that the host issues a stop only when SCL is already held low by an earlier start or byte, and that byte commands come only after a start. The slave model in the bench changes SDA only after it sees a falling SCL edge, and it releases SDA again after the acknowledge slot. The command sequence always begins with a start, runs every write and read value, and closes with a stop. Because of this, the data-stability and end-of-primitive properties are exercised only under legal bus traffic.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_STA_SU,
    S_STA_HI,
    S_STA_HD,
    S_STA_LO,
    S_STO_SU,
    S_STO_HI,
    S_STO_REL,
    S_WB_SU,
    S_WB_HI,
    S_WB_LO,
    S_RB_HI,
    S_RB_LO
  } st_e;
endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2cm_shift_reg.sv
module i2cm_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_d;
  logic              q_en;

  always_comb begin
    q_en = load || shift_en;
    q_d  = load ? load_val : {q[DATA_W-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/i2c_bitbyte_master.sv
module i2c_bitbyte_master #(
  parameter int PHASE_DLY = 250,
  parameter int SETUP_CYC = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_rd_ack,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ack_seen,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              sda_in
);
  import i2cm_pkg::*;

  localparam int PH_LEN  = (PHASE_DLY < 1) ? 1 : PHASE_DLY;
  localparam int SU_LEN  = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int MAX_LEN = (PH_LEN > SU_LEN) ? PH_LEN : SU_LEN;
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int BCNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  PH_LD    = CNT_W'(PH_LEN - 1);
  localparam logic [CNT_W-1:0]  SU_LD    = CNT_W'(SU_LEN - 1);
  localparam logic [BCNT_W-1:0] ACK_SLOT = BCNT_W'(DATA_W);

  // reset: asynchronous assert, synchronous release
  logic rs_q1, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs_q1  <= 1'b1;
      srst_n <= rs_q1;
    end
  end

  st_e               st_q, st_d;
  op_e               op_q, op_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              rdack_q, rdack_d;
  logic              scl_q, scl_d, sda_q, sda_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q;
  logic              ack_q;
  logic              tmr_exp, tmr_load, phase_end;
  logic [CNT_W-1:0]  tmr_val;
  logic [DATA_W-1:0] sreg;
  logic              sh_load, sh_en, cap_rd, cap_ack;
  logic              ctl_en;

  i2cm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(srst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  i2cm_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(srst_n), .load(sh_load), .load_val(cmd_wdata),
    .shift_en(sh_en), .shift_in(sda_in), .q(sreg)
  );

  assign phase_end = (st_q != S_IDLE) && tmr_exp;

  // next-state
  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    bcnt_d  = bcnt_q;
    rdack_d = rdack_q;
    case (st_q)
      S_IDLE: if (cmd_valid) begin
        op_d    = op_e'(cmd_op);
        rdack_d = cmd_rd_ack;
        bcnt_d  = '0;
        case (op_e'(cmd_op))
          OP_START: st_d = S_STA_SU;
          OP_STOP:  st_d = S_STO_SU;
          OP_WRITE: st_d = S_WB_SU;
          default:  st_d = S_RB_HI;
        endcase
      end
      S_STA_SU:  if (phase_end) st_d = S_STA_HI;
      S_STA_HI:  if (phase_end) st_d = S_STA_HD;
      S_STA_HD:  if (phase_end) st_d = S_STA_LO;
      S_STA_LO:  if (phase_end) st_d = S_IDLE;
      S_STO_SU:  if (phase_end) st_d = S_STO_HI;
      S_STO_HI:  if (phase_end) st_d = S_STO_REL;
      S_STO_REL: if (phase_end) st_d = S_IDLE;
      S_WB_SU:   if (phase_end) st_d = S_WB_HI;
      S_WB_HI:   if (phase_end) st_d = S_WB_LO;
      S_RB_HI:   if (phase_end) st_d = S_RB_LO;
      S_WB_LO, S_RB_LO: if (phase_end) begin
        if (bcnt_q == ACK_SLOT) begin
          st_d = S_IDLE;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
          if ((bcnt_q + 1'b1) == ACK_SLOT)
            st_d = (op_q == OP_WRITE) ? S_RB_HI : S_WB_SU;
          else
            st_d = (op_q == OP_WRITE) ? S_WB_SU : S_RB_HI;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // line drive decode for the state being entered
  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    case (st_d)
      S_STA_SU:  sda_d = 1'b0;
      S_STA_HI:  begin scl_d = 1'b0; sda_d = 1'b0; end
      S_STA_HD:  sda_d = 1'b1;
      S_STA_LO:  begin scl_d = 1'b1; sda_d = 1'b1; end
      S_STO_SU:  sda_d = 1'b1;
      S_STO_HI:  begin scl_d = 1'b0; sda_d = 1'b1; end
      S_STO_REL: begin scl_d = 1'b0; sda_d = 1'b0; end
      S_WB_SU: begin
        scl_d = 1'b1;
        if (op_d == OP_READ)     sda_d = rdack_d;
        else if (st_q == S_IDLE) sda_d = ~cmd_wdata[DATA_W-1];
        else                     sda_d = ~sreg[DATA_W-1];
      end
      S_WB_HI:  scl_d = 1'b0;
      S_WB_LO:  begin scl_d = 1'b1; sda_d = 1'b0; end
      S_RB_HI:  begin scl_d = 1'b0; sda_d = 1'b0; end
      S_RB_LO:  begin scl_d = 1'b1; sda_d = 1'b0; end
      default: ;
    endcase
  end

  always_comb begin
    ctl_en   = (st_d != st_q);
    tmr_load = ctl_en && (st_d != S_IDLE);
    tmr_val  = (st_d == S_STA_SU || st_d == S_STO_SU || st_d == S_WB_SU) ? SU_LD : PH_LD;
    sh_load  = (st_q == S_IDLE) && cmd_valid;
    sh_en    = phase_end && (((st_q == S_WB_HI) && (op_q == OP_WRITE)) ||
                             ((st_q == S_RB_HI) && (op_q == OP_READ)));
    cap_rd   = phase_end && (st_q == S_RB_HI) && (op_q == OP_READ) &&
               (bcnt_q == ACK_SLOT - 1'b1);
    cap_ack  = phase_end && (st_q == S_RB_HI) && (op_q == OP_WRITE);
    done_d   = phase_end && (st_d == S_IDLE);
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_START;
      bcnt_q  <= '0;
      rdack_q <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else if (ctl_en) begin
      st_q    <= st_d;
      op_q    <= op_d;
      bcnt_q  <= bcnt_d;
      rdack_q <= rdack_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     rdata_q <= '0;
    else if (cap_rd) rdata_q <= {sreg[DATA_W-2:0], sda_in};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      ack_q <= 1'b0;
    else if (cap_ack) ack_q <= ~sda_in;
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign ack_seen = ack_q;
  assign scl_pull = scl_q;
  assign sda_pull = sda_q;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            busy,
  input logic            done,
  input logic            scl_pull,
  input logic            sda_pull,
  input i2cm_pkg::op_e   op
);
  import i2cm_pkg::*;

  logic byte_op;
  assign byte_op = (op == OP_WRITE) || (op == OP_READ);

  a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_start_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_START) |-> (scl_pull && sda_pull));

  a_r3_stop_ends_released: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_STOP) |-> (!scl_pull && !sda_pull));

  a_r8_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_op && !scl_pull && !$past(scl_pull)) |-> $stable(sda_pull));
endmodule

bind i2c_bitbyte_master i2cm_checker u_chk (
  .clk(clk), .rst_n(srst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .op(op_q)
);

// File: tb/tb_i2c_bitbyte_master.sv
`timescale 1ns/1ps
module tb_i2c_bitbyte_master;
  localparam int PD = 3;
  localparam int SU = 2;
  localparam int T  = (PD < 1) ? 1 : PD;
  localparam int S  = (SU < 1) ? 1 : SU;
  localparam int L_START = S + 3*T;
  localparam int L_STOP  = S + 2*T;
  localparam int L_WRITE = 8*(S + 2*T) + 2*T;
  localparam int L_READ  = 16*T + S + 2*T;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, cmd_valid, cmd_rd_ack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_wdata;
  logic       busy, done, ack_seen, scl_pull, sda_pull;
  logic [7:0] rdata;
  logic       scl_bus, sda_bus, slave_pull;

  int vectors = 0;
  int miscmp  = 0;

  // slave model state
  int         mode = 0;       // 0 idle, 1 receives a write, 2 supplies a read
  logic       slv_ack = 1'b0;
  logic [7:0] rbyte = 8'h00;
  int         fi = 0;
  logic [7:0] cap = 8'h00;
  logic       ninth = 1'b1;
  int         starts = 0, stops = 0;
  logic       scl_prev = 1'b1, sda_prev = 1'b1;

  assign scl_bus = ~scl_pull;
  assign sda_bus = ~(sda_pull | slave_pull);
  assign slave_pull = (mode == 1 && fi == 8 && slv_ack) ||
                      (mode == 2 && fi < 8 && !rbyte[7 - (fi & 7)]);

  i2c_bitbyte_master #(.PHASE_DLY(PD), .SETUP_CYC(SU), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_rd_ack(cmd_rd_ack), .busy(busy), .done(done),
    .rdata(rdata), .ack_seen(ack_seen), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .sda_in(sda_bus)
  );

  always @(negedge clk) begin
    if (!scl_prev && scl_bus) begin
      if (fi < 8) cap = {cap[6:0], sda_bus};
      else if (fi == 8) ninth = sda_bus;
    end
    if (scl_prev && !scl_bus) fi = fi + 1;
    if (scl_prev && scl_bus && sda_prev && !sda_bus) starts = starts + 1;
    if (scl_prev && scl_bus && !sda_prev && sda_bus) stops = stops + 1;
    scl_prev = scl_bus;
    sda_prev = sda_bus;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issues a command, returns cycles until done; inject pulses a stray STOP mid-way
  task automatic run_op(input logic [1:0] op, input logic [7:0] wd, input logic ra,
                        input bit inject, output int n);
    @(negedge clk);
    fi = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_rd_ack = ra;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 2'd0;
    n = 0;
    do begin
      if (inject && n == 5) begin cmd_valid = 1'b1; cmd_op = 2'd1; end
      if (inject && n == 6) cmd_valid = 1'b0;
      @(posedge clk); #1;
      n++;
    end while (!done && n < 2000);
    cmd_valid = 1'b0;
    @(posedge clk); #1;
    chk("R10 done width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    int n, s0, p0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wdata = 8'h00; cmd_rd_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 sda_pull in reset", {31'd0, sda_pull}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 scl_pull", {31'd0, scl_pull}, 32'd0);
    chk("R1 sda_pull", {31'd0, sda_pull}, 32'd0);
    starts = 0; stops = 0;

    // R2 start condition
    run_op(2'd0, 8'h00, 1'b0, 1'b0, n);
    chk("R2 R11 start length", n, L_START);
    chk("R2 start seen", starts, 1);
    chk("R2 lines low", {30'd0, scl_pull, sda_pull}, 32'd3);

    // R4 R5 writes, every byte value
    mode = 1;
    for (int v = 0; v < 256; v++) begin
      slv_ack = v[0] ^ v[3];
      run_op(2'd2, v[7:0], 1'b0, 1'b0, n);
      chk("R4 write byte", {24'd0, cap}, v);
      chk("R5 ack_seen", {31'd0, ack_seen}, {31'd0, slv_ack});
      chk("R11 write length", n, L_WRITE);
    end

    // R9 stray command while busy
    slv_ack = 1'b1;
    p0 = stops;
    run_op(2'd2, 8'hA5, 1'b0, 1'b1, n);
    chk("R9 length unchanged", n, L_WRITE);
    chk("R9 byte unchanged", {24'd0, cap}, 32'hA5);
    repeat (3) begin
      @(posedge clk); #1;
      chk("R9 stays idle", {31'd0, busy}, 32'd0);
    end
    chk("R9 no stop issued", stops, p0);

    // R6 R7 reads, every byte value
    mode = 2;
    for (int v = 0; v < 256; v++) begin
      rbyte = v[7:0];
      run_op(2'd3, 8'h00, v[1], 1'b0, n);
      chk("R6 read byte", {24'd0, rdata}, v);
      chk("R7 master ack level", {31'd0, ninth}, {31'd0, ~v[1]});
      chk("R11 read length", n, L_READ);
    end
    mode = 0;
    chk("R8 no start inside bytes", starts, 1);
    chk("R8 no stop inside bytes", stops, 0);

    // R3 stop condition
    s0 = stops;
    run_op(2'd1, 8'h00, 1'b0, 1'b0, n);
    chk("R3 R11 stop length", n, L_STOP);
    chk("R3 stop seen", stops, s0 + 1);
    chk("R3 lines released", {30'd0, scl_pull, sda_pull}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule